// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block times the serial clock of an I2C master. A power-of-two prescaler divides the source clock and produces a tick. Two 5-bit phase counts then set how many ticks SCL is held low and how many it is left released. Every phase also gets a fixed overhead of ticks. This overhead stands for the input synchroniser and the noise filter on SCL. It is 4 ticks when the prescaler does not divide and 3 ticks when it does.

The high phase is not timed from the moment the block releases SCL. Timing starts only when the line is seen high through a two-stage synchroniser and a one-cycle glitch filter. A target that holds SCL low therefore stretches the period, and the high time it gets is unchanged.

A byte engine drives the block. It asks for clocking with a run level and uses two one-cycle strobes: one marks the start of each low phase, when SDA may change, and one marks the first counted high cycle, when SDA is sampled. When run is dropped, the current period finishes and SCL is then parked low. A separate release input lets SCL go high again once the engine gives up the bus.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, SCL is not driven low and both strobes are 0.
- R2: With divider select 0, a low phase lasts exactly (low count + 4) source cycles. The count is read from the low-count input.
- R3: With divider select s (1..7), a low phase lasts (low count + 3) × 2^s source cycles. The high phase's counted part lasts (high count + 3) × 2^s source cycles.
- R4: When SCL is released and nothing holds it low, the rise strobe comes in the 6th released cycle, so 5 released cycles come before it. From the rise strobe onward, SCL stays released for (high count + overhead) × 2^s cycles. The overhead is 4 for s = 0 and 3 otherwise.
- R5: If a target holds SCL low for k extra cycles after release, the released time before the rise strobe grows by exactly k. The counted high part does not change.
- R6: A mode write takes bits 6:4 of the write data as the divider select only when bit 3 of that data is 1. A write with bit 3 = 0 leaves the divider unchanged.
- R7: A low or high count of 0 is treated as 1.
- R8: If run is low when a high phase ends, SCL is driven low and held low with no fall strobe until run returns. A release pulse while parked with run low lets SCL go high again.
- R9: A single-cycle high pulse on the SCL input while a target holds the line low does not start high-phase counting.
- R10: The fall strobe is one cycle wide and falls in the first cycle of each low phase. The rise strobe falls in the first counted high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 8 | Mode write data: bits 6:4 are the divider select, bit 3 is the write enable for that field |
| lo_cnt | input | 5 | Low-phase count |
| hi_cnt | input | 5 | High-phase count |
| run | input | 1 | Byte engine requests clocking |
| release_bus | input | 1 | Lets SCL go high again while parked |
| scl_in | input | 1 | SCL line as seen at the pad |
| scl_drive_low | output | 1 | Request to pull SCL low |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First counted high cycle |

## Verification
The hardest case to reach is a released SCL that stays low, or that shows a lone one-cycle spike, while the block waits to count the high phase. The bench contains a small target model. After each release, this model holds the line low for a programmed number of cycles and can inject a single-cycle high pulse during that hold. The bench then compares the measured wait and high lengths with the values worked out from the requirements. It also runs the slowest divider, zero counts, a write with the field write enable clear, and the park-and-release sequence.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOW  = 3'd1,
    PH_WAIT = 3'd2,
    PH_HIGH = 3'd3,
    PH_PARK = 3'd4
  } ph_state_e;

  // Extra ticks added to each phase, covering input sync and filter
  localparam int unsigned OVH_UNDIV = 4;
  localparam int unsigned OVH_DIV   = 3;

  // Mode-write field layout
  localparam int unsigned SEL_LSB = 4;
  localparam int unsigned WEN_BIT = 3;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          cnt_en;

  always_comb begin
    lim    = ~({CW{1'b1}} << sel);
    tick   = (cnt_q == lim);
    cnt_en = 1'b1;
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_PSC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim) else $error("prescaler count beyond limit"); // R3

  AST_PSC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)) else $error("prescaler not cleared"); // R3

endmodule

// File: rtl/scl_input_filter.sv
module scl_input_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_seen_high
);

  // pipe_q[SYNC_STAGES-1] is the synchronised level, pipe_q[SYNC_STAGES] the previous one
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;
  logic                 flt_q, flt_d;

  assign pipe_d[0] = scl_in;
  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    assign pipe_d[g] = pipe_q[g-1];
  end

  always_comb begin
    if (pipe_q[SYNC_STAGES-1] == pipe_q[SYNC_STAGES]) flt_d = pipe_q[SYNC_STAGES-1];
    else                                              flt_d = flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      flt_q  <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      flt_q  <= flt_d;
    end
  end

  assign scl_seen_high = flt_q;

  AST_FLT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_q) |-> (flt_q == $past(pipe_q[SYNC_STAGES]) &&
                         flt_q == $past(pipe_q[SYNC_STAGES-1])))
    else $error("filter moved without two agreeing samples"); // R9

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             release_bus,
  input  logic             tick,
  input  logic             scl_seen_high,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  output logic             presc_clr,
  output logic             drive_low,
  output logic             fall_stb,
  output logic             rise_stb
);

  localparam int unsigned PH_W = CNT_W + 1;

  ph_state_e       state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] ovh, eff_lo, eff_hi, tgt;
  logic            counting, phase_end, ph_en;
  logic            drive_q, drive_d, fall_q, fall_d, rise_q, rise_d;

  always_comb begin
    ovh       = (sel == '0) ? PH_W'(OVH_UNDIV) : PH_W'(OVH_DIV);
    eff_lo    = (lo_cnt == '0) ? PH_W'(1) : PH_W'(lo_cnt);
    eff_hi    = (hi_cnt == '0) ? PH_W'(1) : PH_W'(hi_cnt);
    tgt       = (state_q == PH_LOW) ? (eff_lo + ovh) : (eff_hi + ovh);
    counting  = (state_q == PH_LOW) || (state_q == PH_HIGH);
    phase_end = counting && tick && (ph_q == tgt - 1'b1);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (run)           state_d = PH_LOW;
      PH_LOW:  if (phase_end)     state_d = PH_WAIT;
      PH_WAIT: if (scl_seen_high) state_d = PH_HIGH;
      PH_HIGH: if (phase_end)     state_d = run ? PH_LOW : PH_PARK;
      PH_PARK: begin
        if (run)              state_d = PH_LOW;
        else if (release_bus) state_d = PH_IDLE;
      end
      default:                    state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    ph_en = (state_d != state_q) || (counting && tick);
    if (state_d != state_q) ph_d = '0;
    else                    ph_d = ph_q + 1'b1;
    drive_d = (state_d == PH_LOW) || (state_d == PH_PARK);
    fall_d  = (state_d == PH_LOW)  && (state_q != PH_LOW);
    rise_d  = (state_d == PH_HIGH) && (state_q != PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      drive_q <= 1'b0;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign presc_clr = !counting;
  assign drive_low = drive_q;
  assign fall_stb  = fall_q;
  assign rise_stb  = rise_q;

  AST_PH_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (ph_q < tgt)) else $error("phase count overran"); // R2

  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q) else $error("fall strobe wider than one cycle"); // R10

  AST_RISE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_q) |-> $past(scl_seen_high)) else $error("high counted before SCL seen"); // R4

  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_PARK && !run && !release_bus) |=> (drive_q && !fall_q))
    else $error("park did not hold SCL low"); // R8

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic             run,
  input  logic             release_bus,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             fall_stb,
  output logic             rise_stb
);

  logic             rst_meta_q, rst_sync_q;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic             tick, presc_clr, seen_high;
  logic             unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    sel_en = mode_we && mode_wdata[WEN_BIT];
    sel_d  = mode_wdata[SEL_LSB +: SEL_W];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  sel_q <= '0;
    else if (sel_en)  sel_q <= sel_d;
  end

  assign unused_wdata = ^{mode_wdata[7], mode_wdata[2:0]};

  scl_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (presc_clr),
    .sel   (sel_q),
    .tick  (tick)
  );

  scl_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .scl_in        (scl_in),
    .scl_seen_high (seen_high)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .run           (run),
    .release_bus   (release_bus),
    .tick          (tick),
    .scl_seen_high (seen_high),
    .sel           (sel_q),
    .lo_cnt        (lo_cnt),
    .hi_cnt        (hi_cnt),
    .presc_clr     (presc_clr),
    .drive_low     (scl_drive_low),
    .fall_stb      (fall_stb),
    .rise_stb      (rise_stb)
  );

  AST_WEN_GUARD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mode_we && !mode_wdata[WEN_BIT]) |=> $stable(sel_q))
    else $error("divider changed without field write enable"); // R6

endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic [4:0] lo_cnt = 5'd1;
  logic [4:0] hi_cnt = 5'd1;
  logic       run = 1'b0;
  logic       release_bus = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, fall_stb, rise_stb;

  always #2 clk = ~clk;

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .run(run), .release_bus(release_bus),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  // Target model: after release, hold SCL low stretch_n cycles, optional one-cycle spike
  int rel_cnt = 0;
  int stretch_n = 0;
  bit glitch_en = 1'b0;
  always @(posedge clk) rel_cnt <= scl_drive_low ? 0 : rel_cnt + 1;
  assign scl_in = !scl_drive_low && (rel_cnt >= stretch_n || (glitch_en && rel_cnt == 1));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard
  int    q_lo[$], q_wt[$], q_hi[$];
  string q_tag[$];
  bit mon_on = 1'b0, in_low = 1'b0, in_rel = 1'b0, seen = 1'b0, prev_fall = 1'b0;
  int lc = 0, wc = 0, hc = 0, meas_lo = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (in_rel && scl_drive_low) begin
        in_rel = 1'b0;
        if (q_lo.size() == 0) check("R2", "unexpected period", 1, 0);
        else begin
          string t;
          t = q_tag.pop_front();
          check(t, "low length", meas_lo, q_lo.pop_front());
          check(t, "wait before rise", wc, q_wt.pop_front());
          check(t, "high length", hc, q_hi.pop_front());
        end
      end
      if (fall_stb) begin
        check("R10", "fall strobe previous cycle", int'(prev_fall), 0);
        in_low = 1'b1; lc = 1;
      end else if (in_low) begin
        if (scl_drive_low) lc++;
        else begin
          in_low = 1'b0; meas_lo = lc; in_rel = 1'b1; wc = 1; hc = 0; seen = 1'b0;
        end
      end else if (in_rel) begin
        if (rise_stb) begin seen = 1'b1; hc = 1; end
        else if (seen) hc++;
        else wc++;
      end
      prev_fall = fall_stb;
    end
  end

  task automatic run_periods(int sel, int lo, int hi, int st, bit gl, int n, int junk_sel, string tag);
    int dv, ov, el, eh;
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 8'h08 | 8'(sel << 4);
    @(negedge clk);
    if (junk_sel >= 0) begin
      mode_wdata = 8'(junk_sel << 4);
      @(negedge clk);
    end
    mode_we = 1'b0;
    lo_cnt = 5'(lo); hi_cnt = 5'(hi); stretch_n = st; glitch_en = gl;
    dv = 1 << sel; ov = (sel == 0) ? 4 : 3;
    el = (lo == 0) ? 1 : lo; eh = (hi == 0) ? 1 : hi;
    for (int k = 0; k < n; k++) begin
      q_lo.push_back((el + ov) * dv); q_wt.push_back(5 + st);
      q_hi.push_back((eh + ov) * dv); q_tag.push_back(tag);
    end
    run = 1'b1;
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!fall_stb);
    end
    run = 1'b0;
    while (q_lo.size() != 0 || in_rel) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic park_release();
    int falls = 0;
    check("R8", "parked drive low", int'(scl_drive_low), 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (fall_stb || !scl_drive_low) falls++;
    end
    check("R8", "park disturbances", falls, 0);
    release_bus = 1'b1;
    @(negedge clk);
    release_bus = 1'b0;
    @(negedge clk);
    check("R8", "drive after release", int'(scl_drive_low), 0);
    stretch_n = 0; glitch_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "drive low in reset", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "drive low after reset", int'(scl_drive_low), 0);
    check("R1", "fall strobe after reset", int'(fall_stb), 0);
    check("R1", "rise strobe after reset", int'(rise_stb), 0);
    mon_on = 1'b1;

    run_periods(0, 5, 3, 0, 1'b0, 2, -1, "R2 R4 R10");  park_release();
    run_periods(2, 2, 1, 0, 1'b0, 2, -1, "R3");         park_release();
    run_periods(7, 1, 1, 0, 1'b0, 1, -1, "R3 slowest"); park_release();
    run_periods(0, 3, 2, 0, 1'b0, 1, 5,  "R6");         park_release();
    run_periods(1, 0, 0, 0, 1'b0, 2, -1, "R7");         park_release();
    run_periods(0, 4, 4, 7, 1'b0, 2, -1, "R5");         park_release();
    run_periods(0, 2, 2, 6, 1'b1, 2, -1, "R9");         park_release();

    check("R2", "leftover expected periods", q_lo.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule